// File: doc/BRIEF.md
# Multi-Context CRC Accelerator

This block computes CRC signatures over data streams that a bus master (a processor or a DMA engine) writes into it through a simple register bus. It holds three independent contexts. Each context has its own setting, its own running signature and its own input port. Streams may therefore be fed one at a time, interleaved access by access, or alternated byte by byte, and no context affects another. Each context selects a 16-bit generator (0x1021) or a 32-bit generator (0x04C11DB7). It can reflect each input byte before folding it in. On read, it can reverse the bit order of the signature and complement it.

Each bus access lasts one cycle. The width of a data write comes from its byte enables, so one data write folds in one, two or four bytes in that cycle. The byte in lane 0 (`req_wdata[7:0]`) is folded first. Loading a seed is a write to the signature register. Reading the signature returns the transformed view, and the stored running value is left as it was. Any access that has no decode, whether from a bad byte-enable pattern or an unmapped address, is answered with an error and changes nothing.

Word address map: `req_addr[1:0]` selects the register (0 setting, 1 signature, 2 data input, 3 unmapped) and `req_addr[3:2]` selects the context (0 to 2, 3 unmapped).

Top module: `crc_acc`

## Requirements
- R1: The three contexts are independent. Interleaved accesses to one context never change the setting or signature of another.
- R2: Setting bit 0 selects the generator: 0 gives 16-bit 0x1021 and 1 gives 32-bit 0x04C11DB7. Bits are folded MSB-first, and enabled lanes are folded in ascending lane order (lane 0 = `req_wdata[7:0]` first).
- R3: A data write folds exactly the enabled lanes. A byte write uses enables 0001, 0010, 0100 or 1000, a half-word write uses 0011 or 1100, and a word write uses 1111.
- R4: Each access is absorbed at the clock edge where it is presented. Its response (`rsp_valid`, `rsp_err`, `rsp_rdata`) is registered and appears after that edge. Back-to-back accesses every cycle are accepted with no stall. `rsp_valid` is low after a cycle with no request.
- R5: A write to the signature register loads the seed into the enabled lanes only. The other lanes keep their value.
- R6: Setting bit 1 reverses the bit order of the signature as read (over 16 or 32 bits), and setting bit 2 complements it. These transforms never alter the stored running value.
- R7: Setting bit 3 reverses the bit order of each input byte before that byte is folded in.
- R8: In 16-bit mode the signature reads with bits 31:16 equal to zero.
- R9: The following byte-enable patterns return `rsp_err`=1 and leave all state unchanged: the misaligned half-word 0110, non-contiguous patterns, three-lane patterns, and 0000.
- R10: An access to context 3 or to register offset 3 returns `rsp_err`=1 and changes no state.
- R11: The setting register reads back bits 3:0, with all other bits zero. The data input register reads as zero. A write response carries `rsp_rdata`=0.
- R12: After reset every context has setting 0 and signature 0, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address: context in [3:2], register in [1:0] |
| req_be | input | 4 | Byte enables, lane i = bits 8i+7:8i |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | 32 | Read data (zero on write or error) |

## Verification
Every result is due exactly one clock edge after its request. A write changes the context's state at the edge where it is presented, and the registered response of that access is visible just after the same edge. A read issued in the next cycle therefore already returns the updated signature. The bench drives each request at a falling edge and samples the response at the following falling edge. Accesses run back to back, so every sample falls half a period after the edge that produced it. Error cases are confirmed by reading the untouched signature and setting back in later accesses.

// File: rtl/crc_acc_pkg.sv
package crc_acc_pkg;

    parameter int unsigned BUS_W   = 32;
    localparam int unsigned LANES  = BUS_W / 8;
    parameter logic [15:0] GEN16   = 16'h1021;
    parameter logic [31:0] GEN32   = 32'h04C11DB7;

    // setting register, bit 0 = wide, 1 = swap, 2 = invert, 3 = reflect input
    typedef struct packed {
        logic refl_in;
        logic invert;
        logic swap;
        logic wide;
    } ctx_cfg_t;

    typedef enum logic [1:0] {
        RSEL_CFG  = 2'd0,
        RSEL_SIG  = 2'd1,
        RSEL_DIN  = 2'd2,
        RSEL_NONE = 2'd3
    } rsel_t;

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // fold one byte MSB-first into the running value
    function automatic logic [31:0] fold_byte(input logic [31:0] c,
                                              input logic [7:0]  b,
                                              input logic        wide);
        logic [31:0] r;
        logic [15:0] h;
        r = 32'h0;
        if (wide) begin
            r = c ^ {b, 24'h0};
            for (int k = 0; k < 8; k++)
                r = r[31] ? ((r << 1) ^ GEN32) : (r << 1);
        end else begin
            h = c[15:0] ^ {b, 8'h0};
            for (int k = 0; k < 8; k++)
                h = h[15] ? ((h << 1) ^ GEN16) : (h << 1);
            r = {16'h0, h};
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_acc_dec.sv
module crc_acc_dec
    import crc_acc_pkg::*;
#(
    parameter int unsigned N_CTX = 3,
    localparam int unsigned CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic [CTX_W+1:0] addr,
    input  logic [LANES-1:0] be,
    output logic [CTX_W-1:0] ctx_idx,
    output rsel_t            rsel,
    output logic             err
);

    logic be_ok;
    logic addr_ok;

    always_comb begin
        case (be)
            4'b0001, 4'b0010, 4'b0100, 4'b1000,
            4'b0011, 4'b1100,
            4'b1111: be_ok = 1'b1;
            default: be_ok = 1'b0;
        endcase
    end

    always_comb begin
        ctx_idx = addr[CTX_W+1:2];
        rsel    = rsel_t'(addr[1:0]);
        addr_ok = (32'(ctx_idx) < N_CTX) && (rsel != RSEL_NONE);
        err     = !(be_ok && addr_ok);
    end

endmodule

// File: rtl/crc_acc_ctx.sv
module crc_acc_ctx
    import crc_acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg,
    input  logic             wr_sig,
    input  logic             wr_din,
    input  logic [LANES-1:0] be,
    input  logic [BUS_W-1:0] wdata,
    output ctx_cfg_t         cfg_o,
    output logic [31:0]      sig_o
);

    typedef struct packed {
        ctx_cfg_t    cfg;
        logic [31:0] sig;
    } ctx_st_t;

    ctx_st_t st_d, st_q;

    always_comb begin
        logic [31:0] acc;
        logic [7:0]  b;
        st_d = st_q;
        acc  = st_q.sig;
        b    = 8'h0;
        if (wr_cfg && be[0])
            st_d.cfg = ctx_cfg_t'(wdata[3:0]);
        if (wr_sig) begin
            for (int l = 0; l < LANES; l++)
                if (be[l]) st_d.sig[8*l +: 8] = wdata[8*l +: 8];
        end
        if (wr_din) begin
            for (int l = 0; l < LANES; l++) begin
                if (be[l]) begin
                    b   = st_q.cfg.refl_in ? rev8(wdata[8*l +: 8]) : wdata[8*l +: 8];
                    acc = fold_byte(acc, b, st_q.cfg.wide);
                end
            end
            st_d.sig = acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;
    assign sig_o = st_q.sig;

    // R1: a context without a write of its own keeps its state
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_cfg || wr_sig || wr_din) |=> ($stable(st_q.sig) && $stable(st_q.cfg)));

    // R1: the decoder never strobes two registers of one context at once
    p_onehot_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_cfg, wr_sig, wr_din}));

endmodule

// File: rtl/crc_acc_view.sv
module crc_acc_view (
    input  logic        wide,
    input  logic        swap,
    input  logic        invert,
    input  logic [31:0] raw,
    output logic [31:0] view
);

    always_comb begin
        logic [31:0] t;
        t = 32'h0;
        if (wide) begin
            for (int i = 0; i < 32; i++) t[i] = swap ? raw[31-i] : raw[i];
            if (invert) t = ~t;
        end else begin
            for (int i = 0; i < 16; i++) t[i] = swap ? raw[15-i] : raw[i];
            if (invert) t[15:0] = ~t[15:0];
        end
        view = t;
    end

endmodule

// File: rtl/crc_acc.sv
module crc_acc
    import crc_acc_pkg::*;
#(
    parameter int unsigned N_CTX = 3
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         req_valid,
    input  logic                                         req_write,
    input  logic [((N_CTX > 1) ? $clog2(N_CTX) : 1)+1:0] req_addr,
    input  logic [3:0]                                   req_be,
    input  logic [31:0]                                  req_wdata,
    output logic                                         rsp_valid,
    output logic                                         rsp_err,
    output logic [31:0]                                  rsp_rdata
);

    localparam int unsigned CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1;
    localparam int unsigned SLOTS = 1 << CTX_W;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] rdata;
    } rsp_t;

    logic [CTX_W-1:0] dec_ctx;
    rsel_t            dec_rsel;
    logic             dec_err;

    ctx_cfg_t         cfg_a  [SLOTS];
    logic [31:0]      raw_a  [SLOTS];
    logic [31:0]      view_a [SLOTS];

    rsp_t rsp_d, rsp_q;

    crc_acc_dec #(.N_CTX(N_CTX)) u_dec (
        .addr    (req_addr),
        .be      (req_be),
        .ctx_idx (dec_ctx),
        .rsel    (dec_rsel),
        .err     (dec_err)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_ctx
        if (i < N_CTX) begin : g_live
            logic hit;
            assign hit = req_valid && req_write && !dec_err && (dec_ctx == CTX_W'(i));

            crc_acc_ctx u_ctx (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_cfg (hit && (dec_rsel == RSEL_CFG)),
                .wr_sig (hit && (dec_rsel == RSEL_SIG)),
                .wr_din (hit && (dec_rsel == RSEL_DIN)),
                .be     (req_be),
                .wdata  (req_wdata),
                .cfg_o  (cfg_a[i]),
                .sig_o  (raw_a[i])
            );

            crc_acc_view u_view (
                .wide   (cfg_a[i].wide),
                .swap   (cfg_a[i].swap),
                .invert (cfg_a[i].invert),
                .raw    (raw_a[i]),
                .view   (view_a[i])
            );

            // R9: an erroring access leaves every context untouched
            p_err_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && dec_err) |=> ($stable(raw_a[i]) && $stable(cfg_a[i])));
        end else begin : g_idle
            assign cfg_a[i]  = '0;
            assign raw_a[i]  = '0;
            assign view_a[i] = '0;
        end
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && dec_err;
        if (req_valid && !dec_err && !req_write) begin
            case (dec_rsel)
                RSEL_CFG: rsp_d.rdata = {28'h0, cfg_a[dec_ctx]};
                RSEL_SIG: rsp_d.rdata = view_a[dec_ctx];
                default:  rsp_d.rdata = 32'h0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    // R4: every request is answered after the next edge
    p_resp_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4: no response without a request
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err));

    // R9: an error response never carries data
    p_err_nodata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'h0));

endmodule

// File: tb/tb_crc_acc.sv
module tb_crc_acc;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        got_err;
    logic [31:0] got_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_acc dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    // one access, driven at a falling edge, response sampled at the next falling edge
    task automatic acc(input bit wr, input int ctx, input int rg,
                       input logic [3:0] be, input logic [31:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 4'((ctx << 2) | rg);
        req_be    = be;
        req_wdata = d;
        @(negedge clk);
        got_err   = rsp_err;
        got_data  = rsp_rdata;
        if (rsp_valid !== 1'b1) chk("R4 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        req_valid = 1'b0;
    endtask

    task automatic wr_reg(input int ctx, input int rg, input logic [31:0] d);
        acc(1, ctx, rg, 4'b1111, d);
    endtask

    task automatic rd_sig(input int ctx, output logic [31:0] v);
        acc(0, ctx, 1, 4'b1111, 32'h0);
        v = got_data;
    endtask

    function automatic logic [7:0] msg(input int i);
        return 8'(8'h31 + i);
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        chk("R12 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            acc(0, c, 0, 4'b1111, 0);
            chk("R12 setting after reset", got_data, 32'h0);
            rd_sig(c, v);
            chk("R12 signature after reset", v, 32'h0);
        end
    endtask

    task automatic t_ccitt_lanes;
        logic [31:0] v;
        wr_reg(0, 0, 32'h0);
        wr_reg(0, 1, 32'h0000FFFF);
        for (int i = 0; i < 9; i++) begin
            int l = i % 4;
            acc(1, 0, 2, 4'(1 << l), 32'(msg(i)) << (8 * l));
        end
        rd_sig(0, v);
        chk("R2 R3 16-bit over rotating byte lanes", v, 32'h000029B1);
    endtask

    task automatic t_crc32_words;
        logic [31:0] v;
        wr_reg(1, 0, 32'hF);
        wr_reg(1, 1, 32'hFFFFFFFF);
        wr_reg(1, 2, {msg(3), msg(2), msg(1), msg(0)});
        wr_reg(1, 2, {msg(7), msg(6), msg(5), msg(4)});
        acc(1, 1, 2, 4'b0001, {24'h0, msg(8)});
        chk("R4 write response data R11", got_data, 32'h0);
        rd_sig(1, v);
        chk("R6 R7 32-bit reflected words", v, 32'hCBF43926);
        rd_sig(1, v);
        chk("R6 read leaves value intact", v, 32'hCBF43926);
    endtask

    task automatic t_crc32_halves;
        logic [31:0] v;
        wr_reg(2, 0, 32'h5);
        wr_reg(2, 1, 32'hFFFFFFFF);
        for (int k = 0; k < 4; k++) begin
            if (k % 2 == 0) acc(1, 2, 2, 4'b0011, {16'h0, msg(2*k+1), msg(2*k)});
            else            acc(1, 2, 2, 4'b1100, {msg(2*k+1), msg(2*k), 16'h0});
        end
        acc(1, 2, 2, 4'b0100, {8'h0, msg(8), 16'h0});
        rd_sig(2, v);
        chk("R2 R3 R6 32-bit invert over half-words", v, 32'hFC891918);
        wr_reg(2, 0, 32'h1);
        rd_sig(2, v);
        chk("R6 raw value unmodified by invert", v, 32'h0376E6E7);
    endtask

    task automatic t_ccitt_upper_halves;
        logic [31:0] v;
        wr_reg(0, 0, 32'h0);
        wr_reg(0, 1, 32'h0);
        for (int k = 0; k < 4; k++)
            acc(1, 0, 2, 4'b1100, {msg(2*k+1), msg(2*k), 16'h0});
        acc(1, 0, 2, 4'b1000, {msg(8), 24'h0});
        rd_sig(0, v);
        chk("R3 16-bit upper-lane half-words seed 0", v, 32'h000031C3);
    endtask

    task automatic t_interleave;
        logic [31:0] v;
        wr_reg(0, 0, 32'h0);  wr_reg(0, 1, 32'h0000FFFF);
        wr_reg(1, 0, 32'hE);  wr_reg(1, 1, 32'h0000FFFF);
        wr_reg(2, 0, 32'hF);  wr_reg(2, 1, 32'hFFFFFFFF);
        for (int i = 0; i < 9; i++) begin
            acc(1, 0, 2, 4'b0001, {24'h0, msg(i)});
            acc(1, 1, 2, 4'b0010, {16'h0, msg(i), 8'h0});
            acc(1, 2, 2, 4'b1000, {msg(i), 24'h0});
        end
        rd_sig(0, v);  chk("R1 interleaved context 0", v, 32'h000029B1);
        rd_sig(1, v);  chk("R1 R7 R8 interleaved context 1", v, 32'h0000906E);
        rd_sig(2, v);  chk("R1 interleaved context 2", v, 32'hCBF43926);
    endtask

    task automatic t_seed_merge;
        logic [31:0] v;
        wr_reg(2, 0, 32'h1);
        wr_reg(2, 1, 32'h11223344);
        acc(1, 2, 1, 4'b0100, 32'h00AA0000);
        rd_sig(2, v);
        chk("R5 byte seed merge", v, 32'h11AA3344);
        wr_reg(1, 0, 32'h0);
        wr_reg(1, 1, 32'hFFFFFFFF);
        rd_sig(1, v);
        chk("R8 16-bit upper bits read zero", v, 32'h0000FFFF);
    endtask

    task automatic t_errors;
        logic [31:0] v;
        logic [3:0] bad [5] = '{4'b0110, 4'b0101, 4'b0111, 4'b1110, 4'b0000};
        wr_reg(2, 1, 32'h11223344);
        for (int j = 0; j < 5; j++) begin
            acc(1, 2, 1, bad[j], 32'hDEADBEEF);
            chk("R9 bad enables on seed error", {31'h0, got_err}, 32'h1);
            acc(1, 2, 2, bad[j], 32'hDEADBEEF);
            chk("R9 bad enables on data error", {31'h0, got_err}, 32'h1);
        end
        acc(1, 2, 0, 4'b0110, 32'hFFFFFFFF);
        chk("R9 bad enables on setting error", {31'h0, got_err}, 32'h1);
        rd_sig(2, v);
        chk("R9 signature unchanged after errors", v, 32'h11223344);
        acc(0, 2, 0, 4'b1111, 0);
        chk("R9 setting unchanged after errors", got_data, 32'h1);
        acc(1, 3, 1, 4'b1111, 32'h0);
        chk("R10 context 3 error", {31'h0, got_err}, 32'h1);
        acc(1, 2, 3, 4'b1111, 32'h0);
        chk("R10 offset 3 error", {31'h0, got_err}, 32'h1);
        rd_sig(2, v);
        chk("R10 signature unchanged", v, 32'h11223344);
    endtask

    task automatic t_readback;
        wr_reg(0, 0, 32'hFFFFFFF0);
        acc(0, 0, 0, 4'b0011, 0);
        chk("R11 setting readback masked", got_data, 32'h0);
        wr_reg(0, 0, 32'hFFFFFFFF);
        acc(0, 0, 0, 4'b1111, 0);
        chk("R11 setting readback", got_data, 32'h0000000F);
        chk("R11 no error on good read", {31'h0, got_err}, 32'h0);
        acc(0, 0, 2, 4'b1111, 0);
        chk("R11 data register reads zero", got_data, 32'h0);
        @(negedge clk);
        chk("R4 no response after idle cycle", {31'h0, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ccitt_lanes();
        t_crc32_words();
        t_crc32_halves();
        t_ccitt_upper_halves();
        t_interleave();
        t_seed_merge();
        t_errors();
        t_readback();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule